// File: doc/BRIEF.md
# Variable-Page-Size Fully Associative Translation Buffer

This block is a small, fully associative cache of address translations. Each slot holds one completed translation: an aligned virtual base, an aligned physical base, a page-size code and six attribute bits. Slots may hold pages of different sizes at the same time. A slot therefore matches by address range, not by exact tag compare. A lookup presents a 48-bit virtual address. One cycle later the block answers with either a hit (a 52-bit physical address and the attribute bits) or a miss, which the surrounding logic uses to start a page-table walk.

A page walker fills the buffer through the insert channel. An insert goes to the lowest-numbered empty slot while one exists. After that it replaces the least recently used slot. Recency is held as a per-slot age, and a slot becomes the youngest when it is written or when a lookup that asks for it hits it. The only way to clear entries is the reset.

Both request channels use valid/ready. The lookup channel never applies back-pressure (`lk_ready` is tied high). The insert channel is held off (`ins_ready` low) in any cycle that carries a lookup, so an insert waits at most as long as lookups keep arriving back to back. The response channel has no ready: `rsp_valid` pulses for exactly one cycle, one cycle after each lookup, and the consumer must take it then.

Top module: `vptlb`

## Requirements
- R1: After reset every slot is empty, so every lookup misses until an insert has been accepted, and `rsp_valid` is low.
- R2: An accepted insert is written to the lowest-indexed empty slot. When no slot is empty it overwrites the least recently used slot.
- R3: A slot hits a lookup address `va` when it is valid and `vbase <= va < vbase + page_bytes`. At insert, both the virtual base and the physical base are aligned down to the page size by clearing their offset bits.
- R4: Page-size code encoding: 0 is 4 KB, 1 is 2 MB, 2 is 4 MB, and 3 is treated as 4 KB.
- R5: On a hit, `rsp_pa` equals the slot's physical base OR'd with (`va` AND (`page_bytes` - 1)). On a miss, `rsp_pa` is zero.
- R6: On a hit, `rsp_attr` returns the attribute bits stored by the insert: bit 0 writable, bit 1 user, bit 2 no-execute, bit 3 uncacheable, bit 4 global, bit 5 page-attribute-table select. On a miss, `rsp_attr` is zero.
- R7: An accepted insert makes its slot the most recently used. A hitting lookup with `lk_touch` high does the same for the hit slot. A lookup with `lk_touch` low leaves the recency order unchanged.
- R8: `lk_ready` is always high. `rsp_valid` is high exactly in the cycle after each lookup. `ins_ready` equals NOT `lk_valid`, and an insert offered while it is low is not taken.
- R9: When several valid slots match the address, the lowest-indexed one supplies the response.
- R10: Each response carries exactly one of `rsp_hit` and `rsp_miss`. Both are low in cycles without a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; empties every slot |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup ready, always high |
| lk_va | input | 48 | Lookup virtual address |
| lk_touch | input | 1 | Lookup refreshes recency of the hit slot |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert accepted this cycle when high |
| ins_va | input | 48 | Virtual address inside the page to insert |
| ins_pa | input | 52 | Physical address inside the page to insert |
| ins_size | input | 2 | Page-size code (R4) |
| ins_attr | input | 6 | Attribute bits (R6) |
| rsp_valid | output | 1 | Response valid, one cycle after a lookup |
| rsp_hit | output | 1 | Response is a hit |
| rsp_miss | output | 1 | Response is a miss |
| rsp_pa | output | 52 | Translated physical address |
| rsp_attr | output | 6 | Attribute bits of the hit slot |

## Verification
The bench probes each page exactly at its base, at its last byte and one byte past it, and one byte below the base. A design that compared against the wrong page mask, or used `<=` at the top, would hit one byte too far or miss the last byte. The bench fills every slot, refreshes some slots with touching lookups and leaves others with non-touching lookups, and then forces evictions. A design that let untouched lookups age the order, or that evicted the wrong slot, would then lose the wrong translation, and later probes would report a miss where the model expects a hit. Overlapping pages of different sizes check the lowest-index rule. Unaligned insert addresses check base alignment. Inserts offered during a lookup check that an insert is never silently taken or dropped.

// File: rtl/vptlb_pkg.sv
package vptlb_pkg;
  // Widest page offset carried by any supported size (4 MB).
  localparam int OFF_W = 22;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_2M   = 2'd1,
    PG_4M   = 2'd2,
    PG_RSVD = 2'd3
  } pg_size_e;

  // Attribute bits, bit 0 is writable.
  typedef struct packed {
    logic pat;
    logic glb;
    logic ucache;
    logic noexec;
    logic user;
    logic wr;
  } pg_attr_t;

  // Offset mask of a page size code; unknown code is treated as the smallest page.
  function automatic logic [OFF_W-1:0] pg_off_mask(input logic [1:0] code);
    case (pg_size_e'(code))
      PG_2M:   return 22'h1F_FFFF;
      PG_4M:   return 22'h3F_FFFF;
      default: return 22'h00_0FFF;
    endcase
  endfunction
endpackage

// File: rtl/vptlb_pick.sv
// Lowest-index request selector.
module vptlb_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vptlb_match.sv
// Per-slot range comparators: base <= va <= base + mask.
module vptlb_match
  import vptlb_pkg::*;
#(
  parameter int N    = 8,
  parameter int VA_W = 48
) (
  input  logic [N-1:0]           vld,
  input  logic [N-1:0][VA_W-1:0] vbase,
  input  logic [N-1:0][1:0]      sz,
  input  logic [VA_W-1:0]        va,
  output logic [N-1:0]           hit_vec
);
  localparam int PAD = VA_W - OFF_W;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic [VA_W:0] top_addr;
    logic          ge_lo;
    logic          le_hi;
    assign top_addr   = {1'b0, vbase[g]} + {1'b0, {PAD{1'b0}}, pg_off_mask(sz[g])};
    assign ge_lo      = va >= vbase[g];
    assign le_hi      = {1'b0, va} <= top_addr;
    assign hit_vec[g] = vld[g] & ge_lo & le_hi;
  end
endmodule

// File: rtl/vptlb_lru.sv
// Recency tracking with one age counter per slot; age 0 is the youngest.
module vptlb_lru #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  localparam logic [IW-1:0] OLDEST = IW'(N - 1);

  logic [N-1:0][IW-1:0] age;
  logic [IW-1:0]        touched_age;

  assign touched_age = age[touch_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)      age[i] <= '0;
        else if (age[i] < touched_age) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (age[i] == OLDEST) victim_idx = IW'(i);
    end
  end
endmodule

// File: rtl/vptlb.sv
module vptlb
  import vptlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 48,
  parameter int PA_W    = 52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [VA_W-1:0] lk_va,
  input  logic            lk_touch,
  input  logic            ins_valid,
  output logic            ins_ready,
  input  logic [VA_W-1:0] ins_va,
  input  logic [PA_W-1:0] ins_pa,
  input  logic [1:0]      ins_size,
  input  logic [5:0]      ins_attr,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_miss,
  output logic [PA_W-1:0] rsp_pa,
  output logic [5:0]      rsp_attr
);
  localparam int IW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int VPAD = VA_W - OFF_W;
  localparam int PPAD = PA_W - OFF_W;

  logic [ENTRIES-1:0]           ent_vld;
  logic [ENTRIES-1:0][VA_W-1:0] ent_vb;
  logic [ENTRIES-1:0][PA_W-1:0] ent_pb;
  logic [ENTRIES-1:0][1:0]      ent_sz;
  pg_attr_t [ENTRIES-1:0]       ent_at;

  logic [ENTRIES-1:0] hit_vec;
  logic               hit_any, free_any;
  logic [IW-1:0]      hit_idx, free_idx, victim_idx, ins_slot;
  logic               ins_fire, touch;
  logic [IW-1:0]      touch_idx;
  logic [OFF_W-1:0]   ins_mask, hit_mask;

  // Channel rules: lookups always accepted, inserts yield to lookups.
  assign lk_ready  = 1'b1;
  assign ins_ready = ~lk_valid;
  assign ins_fire  = ins_valid & ins_ready;

  vptlb_match #(.N(ENTRIES), .VA_W(VA_W)) u_match (
    .vld     (ent_vld),
    .vbase   (ent_vb),
    .sz      (ent_sz),
    .va      (lk_va),
    .hit_vec (hit_vec)
  );

  vptlb_pick #(.N(ENTRIES), .IW(IW)) u_hit_pick (
    .req (hit_vec),
    .any (hit_any),
    .idx (hit_idx)
  );

  vptlb_pick #(.N(ENTRIES), .IW(IW)) u_free_pick (
    .req (~ent_vld),
    .any (free_any),
    .idx (free_idx)
  );

  assign ins_slot  = free_any ? free_idx : victim_idx;
  assign touch     = ins_fire | (lk_valid & lk_touch & hit_any);
  assign touch_idx = ins_fire ? ins_slot : hit_idx;

  vptlb_lru #(.N(ENTRIES), .IW(IW)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch      (touch),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx)
  );

  // Slot storage; only the valid bits need reset.
  assign ins_mask = pg_off_mask(ins_size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
    end else if (ins_fire) begin
      ent_vld[ins_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_fire) begin
      ent_vb[ins_slot] <= ins_va & ~{{VPAD{1'b0}}, ins_mask};
      ent_pb[ins_slot] <= ins_pa & ~{{PPAD{1'b0}}, ins_mask};
      ent_sz[ins_slot] <= ins_size;
      ent_at[ins_slot] <= pg_attr_t'(ins_attr);
    end
  end

  // Registered response.
  assign hit_mask = pg_off_mask(ent_sz[hit_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_pa    <= '0;
      rsp_attr  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid & hit_any;
      rsp_miss  <= lk_valid & ~hit_any;
      if (lk_valid && hit_any) begin
        rsp_pa   <= ent_pb[hit_idx] | {{PPAD{1'b0}}, lk_va[OFF_W-1:0] & hit_mask};
        rsp_attr <= ent_at[hit_idx];
      end else begin
        rsp_pa   <= '0;
        rsp_attr <= '0;
      end
    end
  end
endmodule

// File: rtl/vptlb_chk.sv
module vptlb_chk #(
  parameter int VA_W = 48,
  parameter int PA_W = 52
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_va,
  input logic            ins_ready,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic [PA_W-1:0] rsp_pa
);
  AST_RSP_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R8
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid); // R8
  AST_INS_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> !ins_ready); // R8
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_miss)); // R10
  AST_RSP_RESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit || rsp_miss)); // R10
  AST_PA_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!rsp_hit || rsp_pa[11:0] == $past(lk_va[11:0]))); // R5
endmodule

bind vptlb vptlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_va     (lk_va),
  .ins_ready (ins_ready),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_pa    (rsp_pa)
);

// File: tb/vptlb_tb.sv
`timescale 1ns/1ps
module vptlb_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_touch = 1'b0;
  logic [47:0] lk_va = '0;
  logic        ins_valid = 1'b0;
  logic [47:0] ins_va = '0;
  logic [51:0] ins_pa = '0;
  logic [1:0]  ins_size = '0;
  logic [5:0]  ins_attr = '0;
  logic        lk_ready, ins_ready, rsp_valid, rsp_hit, rsp_miss;
  logic [51:0] rsp_pa;
  logic [5:0]  rsp_attr;

  always #2 clk = ~clk;

  vptlb u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Behavioural model: slot contents and a recency list, youngest first.
  bit          m_vld[N];
  logic [47:0] m_vb[N];
  logic [51:0] m_pb[N];
  longint unsigned m_bytes[N];
  logic [5:0]  m_at[N];
  int          m_order[$];

  bit          e_rv, e_hit;
  logic [51:0] e_pa;
  logic [5:0]  e_at;

  function automatic longint unsigned sz_bytes(logic [1:0] c);
    if (c == 2'd1) return 64'd1 << 21;
    if (c == 2'd2) return 64'd1 << 22;
    return 64'd1 << 12;
  endfunction

  function automatic int m_find(logic [47:0] va);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && va >= m_vb[i] && longint'(va) < longint'(m_vb[i]) + m_bytes[i])
        return i;
    return -1;
  endfunction

  task automatic m_promote(int s);
    foreach (m_order[k]) if (m_order[k] == s) begin m_order.delete(k); break; end
    m_order.push_front(s);
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One clock: predict, advance the model at the edge, compare at the falling edge.
  task automatic cycle();
    int s;
    #1;
    chk(ins_ready == !lk_valid && lk_ready, "R8", "ready pins", {ins_ready, lk_ready}, {!lk_valid, 1'b1});
    e_rv = lk_valid; e_hit = 0; e_pa = '0; e_at = '0;
    s = lk_valid ? m_find(lk_va) : -1;
    if (s >= 0) begin
      e_hit = 1;
      e_pa  = m_pb[s] | 52'(lk_va & 48'(m_bytes[s] - 1));
      e_at  = m_at[s];
    end
    @(posedge clk);
    if (ins_valid && !lk_valid) begin
      int slot = -1;
      for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
      if (slot < 0) slot = m_order[$];
      m_vld[slot] = 1;
      m_bytes[slot] = sz_bytes(ins_size);
      m_vb[slot] = ins_va & ~48'(m_bytes[slot] - 1);
      m_pb[slot] = ins_pa & ~52'(m_bytes[slot] - 1);
      m_at[slot] = ins_attr;
      m_promote(slot);
    end
    if (s >= 0 && lk_touch) m_promote(s);
    @(negedge clk);
    chk(rsp_valid == e_rv, "R8", "rsp_valid", rsp_valid, e_rv);
    chk(rsp_hit == (e_rv && e_hit) && rsp_miss == (e_rv && !e_hit), "R10",
        "hit/miss", {rsp_hit, rsp_miss}, {e_rv && e_hit, e_rv && !e_hit});
    chk(rsp_pa == e_pa, "R5", "rsp_pa", rsp_pa, e_pa);
    chk(rsp_attr == e_at, "R6", "rsp_attr", rsp_attr, e_at);
  endtask

  task automatic idle();
    lk_valid = 0; ins_valid = 0; cycle();
  endtask

  task automatic look(logic [47:0] va, bit upd);
    lk_valid = 1; lk_va = va; lk_touch = upd; ins_valid = 0; cycle();
    lk_valid = 0;
  endtask

  task automatic put(logic [47:0] va, logic [51:0] pa, logic [1:0] sz, logic [5:0] at);
    lk_valid = 0; ins_valid = 1; ins_va = va; ins_pa = pa; ins_size = sz; ins_attr = at;
    cycle();
    ins_valid = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state and lookups into an empty buffer
    chk(rsp_valid == 0 && rsp_hit == 0, "R1", "reset outputs", {rsp_valid, rsp_hit}, 0);
    idle();
    look(48'h0000_0000_0000, 1);
    look(48'h7FFF_FFFF_F000, 0);

    // R3 R4: one page of each size, probed at both edges and just outside
    put(48'h0000_1234_5678, 52'hA_BCDE_F123, 2'd0, 6'b000011);  // 4 KB
    put(48'h0000_4012_3456, 52'h1_0030_0000, 2'd1, 6'b010101);  // 2 MB, unaligned bases
    put(48'h0000_8076_5432, 52'h2_0012_3456, 2'd2, 6'b101010);  // 4 MB
    put(48'h0000_C000_1000, 52'h3_0000_7000, 2'd3, 6'b111111);  // code 3 -> 4 KB
    look(48'h0000_1234_5000, 0); look(48'h0000_1234_5FFF, 0);
    look(48'h0000_1234_6000, 0); look(48'h0000_1234_4FFF, 0);
    look(48'h0000_4000_0000, 0); look(48'h0000_401F_FFFF, 0);
    look(48'h0000_4020_0000, 0); look(48'h0000_3FFF_FFFF, 0);
    look(48'h0000_8040_0000, 0); look(48'h0000_807F_FFFF, 0);
    look(48'h0000_8080_0000, 0); look(48'h0000_803F_FFFF, 0);
    look(48'h0000_C000_1ABC, 0); look(48'h0000_C000_2000, 0);

    // R9: a small page inside a large one, at a higher slot, loses to the large one
    put(48'h0000_8050_0000, 52'h9_9999_9000, 2'd0, 6'b000001);
    look(48'h0000_8050_0123, 1);

    // R2 R7: fill the rest, refresh some, then evict
    put(48'h0000_0100_0000, 52'h4_0000_0000, 2'd0, 6'b000100);
    put(48'h0000_0200_0000, 52'h5_0000_0000, 2'd0, 6'b001000);
    put(48'h0000_0300_0000, 52'h6_0000_0000, 2'd1, 6'b010000);
    look(48'h0000_1234_5010, 1);   // touch slot 0
    look(48'h0000_4000_0010, 0);   // no touch on slot 1
    put(48'h0000_0400_0000, 52'h7_0000_0000, 2'd0, 6'b100000);
    put(48'h0000_0500_0000, 52'h8_0000_0000, 2'd0, 6'b100001);
    look(48'h0000_4000_0010, 0); look(48'h0000_1234_5010, 0);
    look(48'h0000_8000_0010, 0); look(48'h0000_0400_0010, 0);
    look(48'h0000_0500_0010, 0); look(48'h0000_C000_1010, 0);

    // R8: insert offered during a lookup is held off, then taken
    lk_valid = 1; lk_va = 48'h0000_0600_0000; lk_touch = 0;
    ins_valid = 1; ins_va = 48'h0000_0600_0000; ins_pa = 52'hB_0000_0000;
    ins_size = 2'd0; ins_attr = 6'b000111;
    cycle();
    lk_valid = 0; cycle();
    ins_valid = 0;
    look(48'h0000_0600_0044, 0);

    // Mixed random traffic over a few regions
    for (int t = 0; t < 1500; t++) begin
      logic [47:0] va;
      va = {16'h0, 8'h40 + 8'($urandom_range(0, 3)), 24'($urandom)} & 48'hFFFF_FFFF_FFFF;
      lk_valid = ($urandom_range(0, 3) != 0);
      lk_va = va; lk_touch = $urandom_range(0, 1);
      ins_valid = ($urandom_range(0, 2) == 0);
      ins_va = {16'h0, 8'h40 + 8'($urandom_range(0, 3)), 24'($urandom)};
      ins_pa = {20'($urandom), 32'($urandom)};
      ins_size = 2'($urandom_range(0, 3)); ins_attr = 6'($urandom);
      cycle();
    end
    lk_valid = 0; ins_valid = 0;
    idle();

    // R1: reset empties every slot again
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    m_order.delete();
    look(48'h0000_8000_0010, 0);
    look(48'h0000_0600_0000, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule